// File: doc/BRIEF.md
# Clock Mode Select and Test-Mode Divider

This block turns the three frequency-select inputs, the spread-enable control and a power-on strap into the output-clock operating mode of a multi-group clock generator. It has three kinds of select code. The all-zero code puts every output group into high impedance. One code is a test mode. The rest are normal modes, and in those the block reports the CPU rate and a spread-margin code to the synthesis logic downstream. The PLLs and the modulation waveform are not part of this block.

In test mode an external test clock stands in for the synthesizer. The block divides that clock by fixed integers and drives all seven output groups from it at the same time. CPU, SDRAM and USB run at one half of the test clock, 3V66 at one third, PCI at one eighth, and REF is the test clock itself. APIC runs at one sixteenth or one eighth of the test clock, chosen by a strap that is captured while reset is held. The same strap tells the normal-mode logic whether APIC runs at half the PCI rate or at the full 33.3 MHz.

Top module: `clkmode_sel`

## Requirements
- R1: With sel2, sel1 and sel0 all 0, every bit of grp_oe is 0 and every bit of grp_clk is 0. Group indices are 0 CPU, 1 SDRAM, 2 3V66, 3 PCI, 4 USB, 5 REF, 6 APIC.
- R2: For every select code other than all-zero, every bit of grp_oe is 1.
- R3: In test mode (sel2=0, sel1=0, sel0=1), groups 0, 1 and 4 toggle on every rising test-clock edge, so they run at a divide-by-2 with 50% duty. Group 3 is high for 4 of every 8 test-clock periods. Group 5 equals the test clock.
- R4: In test mode, group 2 has a period of 3 test-clock periods. It is high for 1.5 periods starting at a rising edge: high for the whole of cycle 0 and the first half of cycle 1 of every three cycles.
- R5: In test mode, group 6 divides by 16 (high 8 of 16 periods) when the latched strap is 0 and by 8 (high 4 of 8) when it is 1.
- R6: The strap value is captured on each rising edge while rst is high, and the captured value is driven on apic_fast. Changes on strap_pin after reset is released have no effect on apic_fast or on the APIC test-mode ratio.
- R7: cpu_fast is 1 exactly when the mode is normal (neither the all-zero code nor the test code) and sel0 is 1. A value of 1 stands for 100 MHz and 0 stands for 66.67 MHz.
- R8: ss_code is 00 (off) when ss_en is 0 or when sel2:sel1 is 00. Otherwise sel2:sel1 = 01 gives 11 (−0.6%), 10 gives 01 (−0.25%) and 11 gives 10 (−0.4%).
- R9: All divided groups are held low outside test mode. Cycle 0 is the first rising test-clock edge after the test code is applied, and every divided output goes high on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Test clock; also clocks all internal registers |
| rst | input | 1 | Synchronous active-high reset; strap capture window |
| sel0 | input | 1 | Frequency select bit 0 (pin) |
| sel1 | input | 1 | Frequency select bit 1 (pin) |
| sel2 | input | 1 | Frequency select bit 2 (register bit) |
| ss_en | input | 1 | Spread-spectrum enable |
| strap_pin | input | 1 | APIC rate strap, sampled during reset |
| grp_clk | output | 7 | Per-group test-mode clocks, indexed as in R1 |
| grp_oe | output | 7 | Per-group output drive enables (1 = driven) |
| cpu_fast | output | 1 | CPU rate flag, 1 = 100 MHz |
| ss_code | output | 2 | Spread-margin code |
| apic_fast | output | 1 | Latched strap value |

## Verification
The bench walks through all eight select codes with spread enabled and disabled, under both strap values, which sets apart the high-impedance, test and two normal CPU-rate modes and all four spread margins. In test mode it samples every group in both halves of 48 consecutive test-clock periods against ratios it works out itself. Sampling both halves is what separates the 1.5-period 3V66 shape from a plain divider, and it shows REF following the clock. The strap is flipped after reset in each pass, and the bench confirms that neither apic_fast nor the APIC ratio follows it.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int NGRP = 7;

    // group index order is fixed: bit positions of grp_clk / grp_oe
    typedef enum logic [2:0] {
        G_CPU   = 3'd0,
        G_SDRAM = 3'd1,
        G_V66   = 3'd2,
        G_PCI   = 3'd3,
        G_USB   = 3'd4,
        G_REF   = 3'd5,
        G_APIC  = 3'd6
    } grp_e;

    typedef enum logic [1:0] {
        SS_OFF = 2'b00,
        SS_025 = 2'b01,
        SS_040 = 2'b10,
        SS_060 = 2'b11
    } ss_code_e;

    typedef enum logic [1:0] {
        MD_HIZ,
        MD_TEST,
        MD_SLOW,
        MD_FAST
    } mode_e;

    typedef struct packed {
        mode_e    mode;
        logic     cpu_fast;
        ss_code_e ss;
    } decode_t;

    // default test-mode divide ratios
    localparam int unsigned DEF_DIV_CPU     = 2;
    localparam int unsigned DEF_DIV_SDRAM   = 2;
    localparam int unsigned DEF_DIV_V66     = 3;
    localparam int unsigned DEF_DIV_PCI     = 8;
    localparam int unsigned DEF_DIV_USB     = 2;
    localparam int unsigned DEF_DIV_REF     = 1;
    localparam int unsigned DEF_DIV_APIC_LO = 16;
    localparam int unsigned DEF_DIV_APIC_HI = 8;

    function automatic mode_e sel_to_mode(input logic s2, input logic s1, input logic s0);
        mode_e m;
        if ({s2, s1, s0} == 3'b000)      m = MD_HIZ;
        else if ({s2, s1, s0} == 3'b001) m = MD_TEST;
        else if (s0)                     m = MD_FAST;
        else                             m = MD_SLOW;
        return m;
    endfunction

    function automatic ss_code_e sel_to_spread(input logic s2, input logic s1, input logic en);
        ss_code_e c;
        if (!en) begin
            c = SS_OFF;
        end else begin
            case ({s2, s1})
                2'b01:   c = SS_060;
                2'b10:   c = SS_025;
                2'b11:   c = SS_040;
                default: c = SS_OFF;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/clkmode_decode.sv
module clkmode_decode
    import clkmode_pkg::*;
(
    input  logic    sel0,
    input  logic    sel1,
    input  logic    sel2,
    input  logic    ss_en,
    output decode_t dec
);
    mode_e m;

    always_comb begin
        m            = sel_to_mode(sel2, sel1, sel0);
        dec.mode     = m;
        dec.cpu_fast = (m == MD_FAST);
        // normal modes never have sel2:sel1 == 00, so the map alone gates spread off
        dec.ss       = sel_to_spread(sel2, sel1, ss_en);
    end
endmodule

// File: rtl/clkmode_strap.sv
module clkmode_strap (
    input  logic clk,
    input  logic rst,
    input  logic strap_pin,
    output logic strap_q
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst) q <= strap_pin;
    end

    assign strap_q = q;
endmodule

// File: rtl/clkmode_div.sv
module clkmode_div #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic clk_o
);
    localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned AHI  = (DIV - 1) / 2;

    generate
        if (DIV == 1) begin : g_pass
            assign clk_o = clk & en;
        end else begin : g_cnt
            logic [CW-1:0] cnt;
            logic [CW-1:0] nxt;
            logic          hold;

            assign hold = rst | ~en;
            assign nxt  = (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;

            if ((DIV % 2) == 0) begin : g_even
                logic q;
                always_ff @(posedge clk) begin
                    if (hold) begin
                        cnt <= CW'(DIV - 1);
                        q   <= 1'b0;
                    end else begin
                        cnt <= nxt;
                        q   <= (nxt < CW'(HALF));
                    end
                end
                assign clk_o = q;
            end else begin : g_odd
                logic a;
                logic b;
                always_ff @(posedge clk) begin
                    if (hold) begin
                        cnt <= CW'(DIV - 1);
                        a   <= 1'b0;
                    end else begin
                        cnt <= nxt;
                        a   <= (nxt < CW'(AHI));
                    end
                end
                // half-cycle stretch on the falling edge keeps duty near 50%
                always_ff @(negedge clk) begin
                    if (hold) b <= 1'b0;
                    else      b <= a;
                end
                assign clk_o = a | b;
            end
        end
    endgenerate
endmodule

// File: rtl/clkmode_sel.sv
module clkmode_sel
    import clkmode_pkg::*;
#(
    parameter int unsigned DIV_CPU     = DEF_DIV_CPU,
    parameter int unsigned DIV_SDRAM   = DEF_DIV_SDRAM,
    parameter int unsigned DIV_V66     = DEF_DIV_V66,
    parameter int unsigned DIV_PCI     = DEF_DIV_PCI,
    parameter int unsigned DIV_USB     = DEF_DIV_USB,
    parameter int unsigned DIV_REF     = DEF_DIV_REF,
    parameter int unsigned DIV_APIC_LO = DEF_DIV_APIC_LO,
    parameter int unsigned DIV_APIC_HI = DEF_DIV_APIC_HI
) (
    input  logic            tclk,
    input  logic            rst,
    input  logic            sel0,
    input  logic            sel1,
    input  logic            sel2,
    input  logic            ss_en,
    input  logic            strap_pin,
    output logic [NGRP-1:0] grp_clk,
    output logic [NGRP-1:0] grp_oe,
    output logic            cpu_fast,
    output logic [1:0]      ss_code,
    output logic            apic_fast
);
    localparam int unsigned DIVS [NGRP] = '{DIV_CPU, DIV_SDRAM, DIV_V66, DIV_PCI,
                                            DIV_USB, DIV_REF, DIV_APIC_LO};

    decode_t         dec;
    logic            strap_q;
    logic            test_en;
    logic [NGRP-1:0] div_out;
    logic            apic_hi_out;

    clkmode_decode u_dec (
        .sel0  (sel0),
        .sel1  (sel1),
        .sel2  (sel2),
        .ss_en (ss_en),
        .dec   (dec)
    );

    clkmode_strap u_strap (
        .clk       (tclk),
        .rst       (rst),
        .strap_pin (strap_pin),
        .strap_q   (strap_q)
    );

    assign test_en = (dec.mode == MD_TEST);

    // all dividers share one enable, so they leave the held state on the same edge
    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            clkmode_div #(.DIV(DIVS[g])) u_div (
                .clk   (tclk),
                .rst   (rst),
                .en    (test_en),
                .clk_o (div_out[g])
            );
        end
    endgenerate

    clkmode_div #(.DIV(DIV_APIC_HI)) u_div_apic_hi (
        .clk   (tclk),
        .rst   (rst),
        .en    (test_en),
        .clk_o (apic_hi_out)
    );

    always_comb begin
        grp_clk = div_out;
        grp_clk[G_APIC] = strap_q ? apic_hi_out : div_out[G_APIC];
        grp_clk = grp_clk & {NGRP{test_en}};
    end

    assign grp_oe    = (dec.mode == MD_HIZ) ? '0 : '1;
    assign cpu_fast  = dec.cpu_fast;
    assign ss_code   = dec.ss;
    assign apic_fast = strap_q;
endmodule

// File: rtl/clkmode_sel_chk.sv
module clkmode_sel_chk (
    input logic       tclk,
    input logic       rst,
    input logic       sel0,
    input logic       sel1,
    input logic       sel2,
    input logic       ss_en,
    input logic [6:0] grp_clk,
    input logic [6:0] grp_oe,
    input logic       cpu_fast,
    input logic [1:0] ss_code,
    input logic       apic_fast
);
    logic tm;
    assign tm = ({sel2, sel1, sel0} == 3'b001);

    p_hiz_r1: assert property (@(posedge tclk) disable iff (rst)
        ({sel2, sel1, sel0} == 3'b000) |-> (grp_oe == 7'd0 && grp_clk == 7'd0));

    p_drive_r2: assert property (@(posedge tclk) disable iff (rst)
        ({sel2, sel1, sel0} != 3'b000) |-> (grp_oe == 7'h7f));

    p_cpu_half_r3: assert property (@(posedge tclk) disable iff (rst)
        (tm && $past(tm) && $past(tm, 2)) |-> (grp_clk[0] != $past(grp_clk[0])));

    p_strap_hold_r6: assert property (@(posedge tclk) disable iff (rst)
        !$past(rst) |-> $stable(apic_fast));

    p_cpu_rate_r7: assert property (@(posedge tclk) disable iff (rst)
        cpu_fast |-> (sel0 && (sel1 || sel2)));

    p_spread_off_r8: assert property (@(posedge tclk) disable iff (rst)
        (!ss_en || {sel2, sel1} == 2'b00) |-> (ss_code == 2'b00));

    p_idle_low_r9: assert property (@(posedge tclk) disable iff (rst)
        !tm |-> (grp_clk == 7'd0));
endmodule

bind clkmode_sel clkmode_sel_chk u_chk (
    .tclk      (tclk),
    .rst       (rst),
    .sel0      (sel0),
    .sel1      (sel1),
    .sel2      (sel2),
    .ss_en     (ss_en),
    .grp_clk   (grp_clk),
    .grp_oe    (grp_oe),
    .cpu_fast  (cpu_fast),
    .ss_code   (ss_code),
    .apic_fast (apic_fast)
);

// File: tb/clkmode_sel_bench.sv
module clkmode_sel_bench;
    logic       tclk = 1'b0;
    logic       rst = 1'b1;
    logic       sel0 = 1'b0, sel1 = 1'b0, sel2 = 1'b0;
    logic       ss_en = 1'b0;
    logic       strap_pin = 1'b0;
    logic [6:0] grp_clk;
    logic [6:0] grp_oe;
    logic       cpu_fast;
    logic [1:0] ss_code;
    logic       apic_fast;

    int total = 0;
    int bad = 0;

    always #5 tclk = ~tclk;

    clkmode_sel u_clkmode_sel (
        .tclk      (tclk),
        .rst       (rst),
        .sel0      (sel0),
        .sel1      (sel1),
        .sel2      (sel2),
        .ss_en     (ss_en),
        .strap_pin (strap_pin),
        .grp_clk   (grp_clk),
        .grp_oe    (grp_oe),
        .cpu_fast  (cpu_fast),
        .ss_code   (ss_code),
        .apic_fast (apic_fast)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // expected level of a divide-by-d output in cycle n; half=0 first half, 1 second half
    function automatic int exp_lvl(input int d, input int n, input int half);
        int r;
        if (d == 1) return (half == 0) ? 1 : 0;
        r = n % d;
        if ((d % 2) == 0) return (r < d / 2) ? 1 : 0;
        if (half == 0) return (r <= (d - 1) / 2) ? 1 : 0;
        return (r < (d - 1) / 2) ? 1 : 0;
    endfunction

    function automatic int exp_ss(input int s2, input int s1, input int en);
        if (en == 0) return 0;
        case ({s2[0], s1[0]})
            2'b01:   return 3;
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 0;
        endcase
    endfunction

    task automatic run_test_mode(input int strap);
        int divs [7];
        string tags [7];
        divs = '{2, 2, 3, 8, 2, 1, (strap != 0) ? 8 : 16};
        tags = '{"R3 cpu", "R3 sdram", "R4 v66", "R3 pci", "R3 usb", "R3 ref", "R5 apic"};
        for (int n = 0; n < 48; n++) begin
            @(posedge tclk); #2;
            for (int g = 0; g < 7; g++) begin
                if (n == 0 && divs[g] != 1) chk("R9 first edge", int'(grp_clk[g]), 1);
                chk(tags[g], int'(grp_clk[g]), exp_lvl(divs[g], n, 0));
            end
            @(negedge tclk); #2;
            for (int g = 0; g < 7; g++)
                chk(tags[g], int'(grp_clk[g]), exp_lvl(divs[g], n, 1));
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int strap = 0; strap < 2; strap++) begin
            rst = 1'b1;
            {sel2, sel1, sel0} = 3'b000;
            strap_pin = strap[0];
            repeat (3) @(posedge tclk);
            @(negedge tclk);
            rst = 1'b0;
            #1;
            chk("R1 reset oe", int'(grp_oe), 0);
            chk("R1 reset clk", int'(grp_clk), 0);
            strap_pin = ~strap[0];
            repeat (2) @(posedge tclk);
            #1;
            chk("R6 strap held", int'(apic_fast), strap);

            for (int code = 0; code < 8; code++) begin
                for (int en = 0; en < 2; en++) begin
                    @(negedge tclk);
                    {sel2, sel1, sel0} = code[2:0];
                    ss_en = en[0];
                    #1;
                    chk((code == 0) ? "R1 oe" : "R2 oe", int'(grp_oe), (code == 0) ? 0 : 127);
                    chk("R7 cpu rate", int'(cpu_fast), (code >= 2 && code[0]) ? 1 : 0);
                    chk("R8 spread", int'(ss_code), exp_ss(code[2], code[1], en));
                    chk("R6 apic flag", int'(apic_fast), strap);
                    if (code == 1) begin
                        run_test_mode(strap);
                    end else begin
                        @(posedge tclk); #2;
                        chk((code == 0) ? "R1 clk" : "R9 idle low", int'(grp_clk), 0);
                    end
                    @(negedge tclk);
                    {sel2, sel1, sel0} = 3'b000;
                    @(negedge tclk);
                end
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule